// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the integer execution unit of a small load-store RISC datapath. Each issued operation supplies two 32-bit operands, a 4-bit opcode, a set-flags bit and the carry produced by an external operand shifter. The block returns a 32-bit result and a write-enable for the destination register. It also computes the next value of the four condition flags: negative (N), zero (Z), carry (C) and overflow (V). A flag register inside the block holds those flags between operations. The held carry feeds the carry-using opcodes.

The operations are add and subtract, each with and without carry. There are reverse-subtract forms, which take the second operand minus the first. There are four bitwise operations: AND, OR, exclusive-OR and bit-clear. There are two moves: pass and invert. There are four flag-only operations: compare, compare-negated, test and test-equal. These update the flags and never request a register write.

Operations arrive through a plain issue strobe, `op_valid`. The block takes one operation per clock and applies no back-pressure. The result, write-enable and next-flag outputs are combinational from the current inputs and the held flags. The flag register loads on the clock edge that ends an issue cycle.

Top module: `alu_flagged`

## Requirements
- R1: After reset `flags_q` is 4'b0000. The flag vectors are packed as bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V.
- R2: Opcode values are AND=0, EOR=1, SUB=2, RSB=3, ADD=4, ADC=5, SBC=6, RSC=7, TST=8, TEQ=9, CMP=10, CMN=11, ORR=12, MOV=13, BIC=14, MVN=15. ADD gives a+b. ADC gives a+b+C, where C is the held carry. CMN evaluates a+b.
- R3: SUB gives a−b and SBC gives a−b+C−1. RSB gives b−a and RSC gives b−a+C−1. CMP evaluates a−b. All results are taken modulo 2^32.
- R4: AND, EOR and ORR give the bitwise function of a and b. BIC gives a AND NOT b. MOV gives b and MVN gives NOT b. TST evaluates a AND b and TEQ evaluates a XOR b.
- R5: For arithmetic opcodes the next flags are N = result bit 31 and Z = (result == 0). C is the unsigned carry-out; for subtractions this means C = 1 when no borrow occurs. V is set on signed overflow.
- R6: For AND, EOR, ORR, BIC, TST and TEQ, the next C equals `shift_carry` and V keeps its held value. N and Z come from the result.
- R7: For MOV and MVN, the next N and Z come from the result, and C and V keep their held values.
- R8: TST, TEQ, CMP and CMN never assert `result_we`. They load the flag register whenever issued, whatever `set_flags` is.
- R9: Any other opcode issued with `set_flags` low writes its result and leaves `flags_q` unchanged.
- R10: When `op_valid` is low, `result_we` is low and `flags_q` is unchanged on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | An operation is issued this cycle |
| opcode | input | 4 | Operation code (see R2) |
| set_flags | input | 1 | Request a flag update for non-compare opcodes |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, after the shifter |
| shift_carry | input | 1 | Carry-out of the external shifter |
| result | output | 32 | Operation result |
| result_we | output | 1 | Destination register write-enable |
| flags_next | output | 4 | Flags this operation would produce {N,Z,C,V} |
| flags_q | output | 4 | Held flags {N,Z,C,V} |

## Verification
The assertions assume that `op_valid`, `opcode` and `set_flags` are known at each rising edge once reset is released. They also assume that `shift_carry` is meaningful only for the bitwise opcodes. The properties relate `flags_next` to the held flags and to the operands, and nothing else is assumed of those inputs. The stimulus changes the inputs only on the falling clock edge and holds every control input at a defined value through the run. It covers every opcode with both `set_flags` values and with idle cycles in between, and forces the carry and overflow boundaries: 0x7FFFFFFF+1, 0xFFFFFFFF+1, 0−1 and 0x80000000−1.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;

  typedef enum logic [1:0] {
    CLS_ARITH = 2'd0,
    CLS_LOGIC = 2'd1,
    CLS_MOVE  = 2'd2
  } alu_class_e;
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  localparam int XW = W + 1;
  logic [XW-1:0] wide;

  always_comb begin
    wide = {1'b0, x} + {1'b0, y} + {{(XW-1){1'b0}}, cin};
    sum  = wide[W-1:0];
    cout = wide[W];
    ovf  = (x[W-1] == y[W-1]) && (wide[W-1] != x[W-1]);
  end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int W = 32
) (
  input  alu_pkg::alu_op_e op,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  output logic [W-1:0]     y
);
  import alu_pkg::*;

  always_comb begin
    unique case (op)
      OP_AND, OP_TST: y = a & b;
      OP_EOR, OP_TEQ: y = a ^ b;
      OP_ORR:         y = a | b;
      OP_BIC:         y = a & ~b;
      OP_MOV:         y = b;
      OP_MVN:         y = ~b;
      default:        y = '0;
    endcase
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  alu_pkg::alu_flags_t d,
  output alu_pkg::alu_flags_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/alu_flagged.sv
module alu_flagged #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [3:0]   opcode,
  input  logic         set_flags,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         shift_carry,
  output logic [W-1:0] result,
  output logic         result_we,
  output logic [3:0]   flags_next,
  output logic [3:0]   flags_q
);
  import alu_pkg::*;

  alu_op_e    op;
  alu_class_e cls;
  alu_flags_t cur, nxt;
  logic       flag_only, load;
  logic [W-1:0] ax, ay, sum, bw;
  logic       acin, cout, ovf;

  assign op        = alu_op_e'(opcode);
  assign flag_only = (opcode[3:2] == 2'b10);

  always_comb begin
    unique case (op)
      OP_AND, OP_EOR, OP_TST, OP_TEQ, OP_ORR, OP_BIC: cls = CLS_LOGIC;
      OP_MOV, OP_MVN:                                 cls = CLS_MOVE;
      default:                                        cls = CLS_ARITH;
    endcase
  end

  // Adder operand routing: subtraction uses x + ~y + carry-in.
  always_comb begin
    ax = op_a; ay = op_b; acin = 1'b0;
    unique case (op)
      OP_ADC:         acin = cur.c;
      OP_SUB, OP_CMP: begin ay = ~op_b; acin = 1'b1;  end
      OP_SBC:         begin ay = ~op_b; acin = cur.c; end
      OP_RSB:         begin ax = op_b; ay = ~op_a; acin = 1'b1;  end
      OP_RSC:         begin ax = op_b; ay = ~op_a; acin = cur.c; end
      default:        ;
    endcase
  end

  alu_adder #(.W(W)) u_add (
    .x(ax), .y(ay), .cin(acin), .sum(sum), .cout(cout), .ovf(ovf)
  );

  alu_bitwise #(.W(W)) u_bw (
    .op(op), .a(op_a), .b(op_b), .y(bw)
  );

  assign result = (cls == CLS_ARITH) ? sum : bw;

  always_comb begin
    nxt.n = result[W-1];
    nxt.z = (result == '0);
    unique case (cls)
      CLS_ARITH: begin nxt.c = cout;        nxt.v = ovf;   end
      CLS_LOGIC: begin nxt.c = shift_carry; nxt.v = cur.v; end
      default:   begin nxt.c = cur.c;       nxt.v = cur.v; end
    endcase
  end

  assign load       = op_valid && (set_flags || flag_only);
  assign result_we  = op_valid && !flag_only;
  assign flags_next = nxt;
  assign flags_q    = cur;

  alu_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n), .load(load), .d(nxt), .q(cur)
  );
endmodule

// File: rtl/alu_flagged_chk.sv
module alu_flagged_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic [3:0]   opcode,
  input logic         set_flags,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         shift_carry,
  input logic [W-1:0] result,
  input logic         result_we,
  input logic [3:0]   flags_next,
  input logic [3:0]   flags_q
);
  logic is_test, is_move, is_logic;
  assign is_test  = (opcode[3:2] == 2'b10);
  assign is_move  = (opcode == 4'd13) || (opcode == 4'd15);
  assign is_logic = (opcode == 4'd0) || (opcode == 4'd1) || (opcode == 4'd8) ||
                    (opcode == 4'd9) || (opcode == 4'd12) || (opcode == 4'd14);

  AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    is_test |-> !result_we);  // R8
  AST_TEST_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && is_test |=> flags_q == $past(flags_next));  // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(flags_q));  // R10
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !result_we);  // R10
  AST_NOSET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !set_flags && !is_test |=> $stable(flags_q));  // R9
  AST_MOVE_KEEP_CV: assert property (@(posedge clk) disable iff (!rst_n)
    is_move |-> flags_next[1:0] == flags_q[1:0]);  // R7
  AST_LOGIC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    is_logic |-> (flags_next[1] == shift_carry) && (flags_next[0] == flags_q[0]));  // R6
  AST_SUB_NO_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    opcode == 4'd2 |-> flags_next[1] == (op_a >= op_b));  // R5
endmodule

bind alu_flagged alu_flagged_chk #(.W(W)) u_chk (.*);

// File: tb/sim_alu_flagged.sv
`timescale 1ns/1ps
module sim_alu_flagged;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  opcode = 4'd0;
  logic        set_flags = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        shift_carry = 1'b0;
  logic [31:0] result;
  logic        result_we;
  logic [3:0]  flags_next, flags_q;

  int tests = 0, fails = 0;
  logic [3:0] mf = 4'b0000;  // model flags {N,Z,C,V}

  always #2 clk = ~clk;  // 250 MHz

  alu_flagged u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .set_flags(set_flags), .op_a(op_a), .op_b(op_b), .shift_carry(shift_carry),
    .result(result), .result_we(result_we), .flags_next(flags_next), .flags_q(flags_q)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic string res_tag(input logic [3:0] op);
    if (op == 4 || op == 5 || op == 11) return "R2";
    if (op == 2 || op == 3 || op == 6 || op == 7 || op == 10) return "R3";
    return "R4";
  endfunction

  task automatic step(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic sf, input logic sc, input logic v);
    longint ua, ub, sa, sb, t, st;
    logic [31:0] er;
    logic [3:0]  enf;
    logic        ew, cmp, ar, mv, cy;
    string       ft;
    @(negedge clk);
    op_valid = v; opcode = op; set_flags = sf; op_a = a; op_b = b; shift_carry = sc;
    #1;
    ua = longint'(a); ub = longint'(b);
    sa = longint'($signed(a)); sb = longint'($signed(b));
    cy = mf[1];
    cmp = (op >= 8 && op <= 11);
    mv  = (op == 13 || op == 15);
    ar  = (op >= 2 && op <= 7) || op == 10 || op == 11;
    enf = mf;
    er  = '0;
    case (op)
      4, 11: begin t = ua + ub; st = sa + sb; end
      5:     begin t = ua + ub + cy; st = sa + sb + cy; end
      2, 10: begin t = ua - ub; st = sa - sb; end
      6:     begin t = ua - ub + cy - 1; st = sa - sb + cy - 1; end
      3:     begin t = ub - ua; st = sb - sa; end
      7:     begin t = ub - ua + cy - 1; st = sb - sa + cy - 1; end
      default: begin t = 0; st = 0; end
    endcase
    case (op)
      0, 8:  er = a & b;
      1, 9:  er = a ^ b;
      12:    er = a | b;
      14:    er = a & ~b;
      13:    er = b;
      15:    er = ~b;
      default: er = t[31:0];
    endcase
    enf[3] = er[31];
    enf[2] = (er == 0);
    if (ar) begin
      if (op == 4 || op == 5 || op == 11) enf[1] = (t > 64'sd4294967295);
      else                                enf[1] = (t >= 0);
      enf[0] = (st > 64'sd2147483647) || (st < -64'sd2147483648);
      ft = "R5";
    end else if (mv) ft = "R7";
    else begin
      enf[1] = sc;
      ft = "R6";
    end
    if (cmp) ft = "R8";
    ew = v && !cmp;
    check(res_tag(op), "result", result, er);
    check(!v ? "R10" : (cmp ? "R8" : "R2"), "result_we", {31'b0, result_we}, {31'b0, ew});
    check(ft, "flags_next", {28'b0, flags_next}, {28'b0, enf});
    check(!v ? "R10" : (!sf && !cmp ? "R9" : ft), "flags_q",
          {28'b0, flags_q}, {28'b0, mf});
    if (v && (sf || cmp)) mf = enf;
    @(posedge clk);
  endtask

  initial begin : watchdog
    #400000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "flags_q after reset", {28'b0, flags_q}, 32'h0);
    rst_n = 1'b1;
    @(posedge clk);
    // R5 overflow and carry boundaries
    step(4'd4, 32'h7FFFFFFF, 32'h1, 1, 0, 1);
    step(4'd4, 32'hFFFFFFFF, 32'h1, 1, 0, 1);
    step(4'd5, 32'h10, 32'h20, 1, 0, 1);        // R2 ADC with C=1
    step(4'd2, 32'h5, 32'h5, 1, 0, 1);
    step(4'd2, 32'h0, 32'h1, 1, 0, 1);
    step(4'd6, 32'h100, 32'h1, 1, 0, 1);        // R3 SBC with C=0
    step(4'd2, 32'h80000000, 32'h1, 1, 0, 1);
    step(4'd3, 32'h3, 32'h10, 1, 0, 1);
    step(4'd7, 32'h3, 32'h10, 1, 0, 1);
    // R4 / R6 bitwise with shifter carry
    step(4'd0, 32'hF0F0F0F0, 32'h0FF00FF0, 1, 1, 1);
    step(4'd1, 32'hAAAA5555, 32'hFFFF0000, 1, 0, 1);
    step(4'd12, 32'h0, 32'h0, 1, 1, 1);
    step(4'd14, 32'h11111111, 32'h10011010, 1, 0, 1);
    // R7 moves keep C and V
    step(4'd4, 32'hFFFFFFFF, 32'h1, 1, 0, 1);
    step(4'd13, 32'h0, 32'h80000000, 1, 0, 1);
    step(4'd15, 32'h0, 32'hFFFFFFFF, 1, 1, 1);
    // R8 flag-only operations with set_flags low
    step(4'd10, 32'h7, 32'h9, 0, 0, 1);
    step(4'd11, 32'h7FFFFFFF, 32'h7FFFFFFF, 0, 0, 1);
    step(4'd8, 32'h0F, 32'hF0, 0, 1, 1);
    step(4'd9, 32'h1234, 32'h1234, 0, 0, 1);
    // R9 no flag update without set_flags
    step(4'd2, 32'h0, 32'h1, 0, 0, 1);
    step(4'd0, 32'h0, 32'h0, 0, 1, 1);
    // R10 idle cycles
    step(4'd10, 32'h1, 32'h2, 1, 1, 0);
    step(4'd4, 32'h0, 32'h0, 1, 0, 0);
    step(4'd2, 32'h1, 32'h1, 1, 0, 1);
    for (int i = 0; i < 600; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if (i % 7 == 0) rb = ra;
      if (i % 11 == 0) ra = 32'h80000000;
      step(4'($urandom_range(0, 15)), ra, rb, 1'($urandom), 1'($urandom),
           ($urandom_range(0, 4) != 0));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule